// File: doc/BRIEF.md
# Idle-Qualified Transactional Clock Gate Controller

This block decides, for each of a set of transactional accelerator modules, whether that module's clock runs during the active power state. Software holds one hint bit per module. A hint of 1 asks for the clock and is granted without condition. A hint of 0 only permits the clock to stop: the gate closes once the module reports idle, and stays open while the module is busy. The block keeps a status vector with the real gate state, because a 0 hint alone does not show whether the clock has stopped.

A root enable from the power manager overrides every hint. When the root enable is low, every gate is forced off. Software reaches the hint and status vectors through a plain register write/read port. Address 0 selects the hint vector, which can be written and read. Address 1 selects the status vector, which is read-only. Each gate enable is a registered level meant to drive a clock-gate cell elsewhere. The port has no stream traffic, so it has no valid/ready handshake: a write takes effect on the clock edge where `wr_en` is high, and reads are combinational.

Top module: `txn_clkgate_ctrl`

## Requirements
- R1: There are NUM_CLK (default 5) gates. Each gate depends only on its own hint bit, its own idle bit and the shared root enable.
- R2: After reset, the hint vector reads all ones, the status vector reads all ones, and every `gate_en_o` bit is 1.
- R3: A write of 1 to hint bit i (address 0) with `root_en_i` high turns gate i on at the second rising edge after the write, whatever `idle_i[i]` is.
- R4: While hint bit i is 0 and `idle_i[i]` is 0, an open gate i stays open.
- R5: While hint bit i is 0, an open gate i closes at the first rising edge where `idle_i[i]` is sampled high.
- R6: When `root_en_i` is sampled low, every gate is off after that edge, whatever the hints are. When the root enable returns, a gate whose hint is 1 reopens and a gate whose hint is 0 stays closed.
- R7: A closed gate whose hint is 0 stays closed when its idle bit drops. Only a hint of 1 reopens it.
- R8: `rd_data_o` shows the hint vector when `rd_addr_i` is 0 and the status vector (bit i = `gate_en_o[i]`) when `rd_addr_i` is 1.
- R9: A write to address 1 (status) changes neither the hint vector nor any gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 = hint, 1 = status (ignored) |
| wr_data_i | input | NUM_CLK | Write data |
| rd_addr_i | input | 1 | Read address: 0 = hint, 1 = status |
| rd_data_o | output | NUM_CLK | Read data |
| idle_i | input | NUM_CLK | Per-module idle indication |
| root_en_i | input | 1 | Root clock enable from the power manager |
| gate_en_o | output | NUM_CLK | Per-module registered clock enable |

## Verification
The bench clears a hint while its module is busy and holds it there for several cycles. A design that honoured the hint without waiting for idle would drop that clock at once. The bench then raises idle for one module and lowers it again after the gate closes. This catches a gate that waits an extra cycle, or that reopens by itself when the module turns busy again. It also writes the status address, cycles the root enable with mixed hints, and sets a hint while idle is low. A design that let status writes through, kept a gate open in low power, or made power-up wait for idle would fail there.

// File: rtl/txn_cg_pkg.sv
package txn_cg_pkg;
  typedef enum logic {
    SEL_HINT   = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/txn_hint_regs.sv
module txn_hint_regs #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         wr_addr_i,
  input  logic [N-1:0] wr_data_i,
  output logic [N-1:0] hint_o
);
  localparam logic [N-1:0] HintReset = {N{1'b1}};

  logic hint_we;
  assign hint_we = wr_en_i && (wr_addr_i == txn_cg_pkg::SEL_HINT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hint_o <= HintReset;
    else if (hint_we) hint_o <= wr_data_i;
  end
endmodule

// File: rtl/txn_gate_cell.sv
module txn_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic root_en_i,
  input  logic hint_i,
  input  logic idle_i,
  output logic gate_en_o
);
  logic gate_d;

  always_comb begin
    if (!root_en_i) gate_d = 1'b0;
    else if (hint_i) gate_d = 1'b1;
    else if (idle_i) gate_d = 1'b0;
    else gate_d = gate_en_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_en_o <= 1'b1;
    else gate_en_o <= gate_d;
  end
endmodule

// File: rtl/txn_readback.sv
module txn_readback #(
  parameter int N = 5
) (
  input  logic         rd_addr_i,
  input  logic [N-1:0] hint_i,
  input  logic [N-1:0] status_i,
  output logic [N-1:0] rd_data_o
);
  always_comb begin
    unique case (rd_addr_i)
      txn_cg_pkg::SEL_HINT:   rd_data_o = hint_i;
      txn_cg_pkg::SEL_STATUS: rd_data_o = status_i;
      default:                rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/txn_clkgate_ctrl.sv
module txn_clkgate_ctrl #(
  parameter int NUM_CLK = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [NUM_CLK-1:0] wr_data_i,
  input  logic               rd_addr_i,
  output logic [NUM_CLK-1:0] rd_data_o,
  input  logic [NUM_CLK-1:0] idle_i,
  input  logic               root_en_i,
  output logic [NUM_CLK-1:0] gate_en_o
);
  logic [NUM_CLK-1:0] hint_q;

  txn_hint_regs #(.N(NUM_CLK)) u_hints (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .hint_o    (hint_q)
  );

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_gate
    txn_gate_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .root_en_i (root_en_i),
      .hint_i    (hint_q[g]),
      .idle_i    (idle_i[g]),
      .gate_en_o (gate_en_o[g])
    );
  end

  txn_readback #(.N(NUM_CLK)) u_rd (
    .rd_addr_i (rd_addr_i),
    .hint_i    (hint_q),
    .status_i  (gate_en_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/txn_cg_checker.sv
module txn_cg_checker #(
  parameter int N = 5
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic         wr_addr_i,
  input logic         root_en_i,
  input logic [N-1:0] idle_i,
  input logic [N-1:0] hint_q,
  input logic [N-1:0] gate_en_o
);
  // R6: low power forces every gate off
  assert_lowpower_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !root_en_i |=> (gate_en_o == '0));

  // R9: status writes leave the hints alone
  assert_status_wr_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == txn_cg_pkg::SEL_STATUS) |=> $stable(hint_q));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3: a set hint opens the gate regardless of idle
    assert_hint_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (root_en_i && hint_q[i]) |=> gate_en_o[i]);
    // R4: busy module keeps its clock
    assert_busy_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (root_en_i && !hint_q[i] && !idle_i[i] && gate_en_o[i]) |=> gate_en_o[i]);
    // R5: idle with cleared hint closes the gate
    assert_idle_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hint_q[i] && idle_i[i]) |=> !gate_en_o[i]);
    // R7: closed gate with cleared hint stays closed
    assert_stay_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hint_q[i] && !gate_en_o[i]) |=> !gate_en_o[i]);
  end
endmodule

bind txn_clkgate_ctrl txn_cg_checker #(.N(NUM_CLK)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .root_en_i (root_en_i),
  .idle_i    (idle_i),
  .hint_q    (hint_q),
  .gate_en_o (gate_en_o)
);

// File: tb/txn_clkgate_ctrl_test.sv
`timescale 1ns/1ps
module txn_clkgate_ctrl_test;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_addr = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic         rd_addr = 1'b0;
  logic [N-1:0] rd_data;
  logic [N-1:0] idle = '0;
  logic         root_en = 1'b1;
  logic [N-1:0] gate_en;

  always #2.5 clk = ~clk;

  txn_clkgate_ctrl #(.NUM_CLK(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .idle_i(idle), .root_en_i(root_en), .gate_en_o(gate_en)
  );

  typedef struct {
    string        tag;
    logic [N-1:0] gate;
    logic [N-1:0] rd;
  } exp_t;

  exp_t   sb_q[$];
  int     n_checks = 0;
  int     n_fail = 0;
  logic [N-1:0] m_hint = '1;
  logic [N-1:0] m_gate = '1;

  // Driver: one cycle of stimulus; pushes expected outputs after the next edge
  task automatic drive(input string tag, input logic we, input logic wa,
                       input logic [N-1:0] wd, input logic [N-1:0] id,
                       input logic re, input logic ra);
    exp_t e;
    logic [N-1:0] g_next;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; idle = id; root_en = re; rd_addr = ra;
    for (int i = 0; i < N; i++) begin
      if (!re) g_next[i] = 1'b0;
      else if (m_hint[i]) g_next[i] = 1'b1;
      else if (id[i]) g_next[i] = 1'b0;
      else g_next[i] = m_gate[i];
    end
    m_gate = g_next;
    if (we && !wa) m_hint = wd;
    e.tag = tag; e.gate = m_gate; e.rd = ra ? m_gate : m_hint;
    sb_q.push_back(e);
    @(posedge clk);
  endtask

  // Monitor: compares after each edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (gate_en !== e.gate || rd_data !== e.rd) begin
        n_fail++;
        $display("FAIL %s: gate=%b rd=%b expected gate=%b rd=%b",
                 e.tag, gate_en, rd_data, e.gate, e.rd);
      end
    end
  end

  task automatic check_now(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #12;
    // R2: reset values
    check_now("R2 gate", gate_en, 5'h1f);
    rd_addr = 1'b0; #0.1;
    check_now("R2 hint", rd_data, 5'h1f);
    rd_addr = 1'b1; #0.1;
    check_now("R2 status", rd_data, 5'h1f);
    rst_n = 1'b1;

    drive("R2 idle run", 0, 0, '0, '0, 1, 1);
    // R4: clear hint 0 while module 0 busy
    drive("R4 write", 1, 0, 5'h1e, '0, 1, 0);
    for (int k = 0; k < 4; k++) drive("R4 busy hold", 0, 0, '0, '0, 1, 1);
    // R5: idle seen -> off
    drive("R5 idle", 0, 0, '0, 5'h01, 1, 1);
    // R7: leaves idle, stays off
    for (int k = 0; k < 3; k++) drive("R7 stay off", 0, 0, '0, '0, 1, 1);
    // R9: write to status ignored
    drive("R9 status write", 1, 1, 5'h1f, '0, 1, 0);
    drive("R9 hint readback", 0, 0, '0, '0, 1, 0);
    drive("R9 status readback", 0, 0, '0, '0, 1, 1);
    // R3: set hint with module busy -> on
    drive("R3 write", 1, 0, 5'h1f, '0, 1, 0);
    drive("R3 on", 0, 0, '0, '0, 1, 1);
    drive("R3 on hold", 0, 0, '0, '0, 1, 1);
    // R1: independent gates
    drive("R1 clear all", 1, 0, 5'h00, 5'h15, 1, 0);
    drive("R1 mixed idle", 0, 0, '0, 5'h15, 1, 1);
    drive("R1 hold", 0, 0, '0, '0, 1, 1);
    drive("R8 hint read", 1, 0, 5'h0a, '0, 1, 0);
    drive("R8 status read", 0, 0, '0, '0, 1, 1);
    // R6: low power
    drive("R6 root low", 0, 0, '0, '0, 0, 1);
    drive("R6 root low hold", 1, 0, 5'h1f, '0, 0, 1);
    drive("R6 root back", 1, 0, 5'h03, '0, 1, 1);
    drive("R6 reopen", 0, 0, '0, '0, 1, 1);
    drive("R6 settle", 0, 0, '0, 5'h1f, 1, 0);
    drive("R6 final", 0, 0, '0, '0, 1, 1);
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule